// File: doc/BRIEF.md
# Four-State Moore Sequence Recogniser

This block is a small synchronous Moore machine. It reads one serial bit per clock and keeps a two-bit state code in a pair of flip-flops. On every rising clock edge it moves to a new state chosen by a fixed, irregular transition graph. Its single output depends only on the state it has reached. The output is a flop of its own, loaded with the low bit of the next state, so it always agrees with the low bit of the state register. A synchronous active-high reset returns the machine to code 00. The state code is also brought out as a port so that surrounding logic can observe where the machine stands.

The block suits control paths that follow a short serial pattern. A caller drives the input bit once per cycle and reads the output (and the state, if needed) after each edge. One edge separates an input from its effect.

Top module: `seq4_moore`

## Requirements
- R1: When `rst` is high at a rising clock edge, after that edge `state_o` is 00 and `dout` is 0.
- R2: After every edge, `dout` equals bit 0 of `state_o`. It is 1 in codes 01 and 11, and 0 in codes 00 and 10.
- R3: From code 00, input 0 leaves the state at 00, and input 1 moves it to 01.
- R4: From code 01, input 0 moves the state to 11, and input 1 moves it to 00.
- R5: From code 10, input 0 moves the state to 00, and input 1 moves it to 01.
- R6: From code 11, input 0 moves the state to 10, and input 1 moves it to 00.
- R7: Reset overrides the input. With `rst` high, `din` = 1 still gives code 00, and reset taken from any state (including 11) gives 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input bit, sampled at each rising edge |
| dout | output | 1 | Registered Moore output (low bit of the state) |
| state_o | output | 2 | Current state code |

## Verification
The bench builds the block with its default parameters: a two-bit state register that resets to code 00. Only these values give the four-code graph the requirements define, so the bench does not vary them. With them, every code can be reached from reset in at most three inputs. The bench walks all eight state/input pairs, one by one, from a fresh reset. It also applies reset with the input high and from the deepest state, to show that reset wins over the input.

// File: rtl/seq4_pkg.sv
package seq4_pkg;

  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    S_Q0 = 2'b00,
    S_Q1 = 2'b01,
    S_Q2 = 2'b10,
    S_Q3 = 2'b11
  } st_e;

  localparam st_e ST_RESET = S_Q0;

endpackage

// File: rtl/seq4_next.sv
module seq4_next
  import seq4_pkg::*;
(
  input  st_e  cur_i,
  input  logic bit_i,
  output st_e  nxt_o
);

  always_comb begin
    unique case (cur_i)
      S_Q0:    nxt_o = bit_i ? S_Q1 : S_Q0;
      S_Q1:    nxt_o = bit_i ? S_Q0 : S_Q3;
      S_Q2:    nxt_o = bit_i ? S_Q1 : S_Q0;
      S_Q3:    nxt_o = bit_i ? S_Q0 : S_Q2;
      default: nxt_o = S_Q0;
    endcase
  end

endmodule

// File: rtl/seq4_state_reg.sv
module seq4_state_reg #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= INIT;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/seq4_out_reg.sv
module seq4_out_reg
  import seq4_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_e  nxt_i,
  output logic out_o
);

  // Moore decode taken from the upcoming state so the output is a flop
  logic dec;
  assign dec = nxt_i[0];

  always_ff @(posedge clk) begin
    if (rst) out_o <= ST_RESET[0];
    else     out_o <= dec;
  end

endmodule

// File: rtl/seq4_moore.sv
module seq4_moore
  import seq4_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  output logic            dout,
  output logic [ST_W-1:0] state_o
);

  st_e             cur;
  st_e             nxt;
  logic [ST_W-1:0] cur_raw;

  assign cur     = st_e'(cur_raw);
  assign state_o = cur_raw;

  seq4_next u_next (
    .cur_i (cur),
    .bit_i (din),
    .nxt_o (nxt)
  );

  seq4_state_reg #(
    .W    (ST_W),
    .INIT (ST_RESET)
  ) u_state (
    .clk (clk),
    .rst (rst),
    .d_i (nxt),
    .q_o (cur_raw)
  );

  seq4_out_reg u_out (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt),
    .out_o (dout)
  );

endmodule

// File: rtl/seq4_moore_chk.sv
module seq4_moore_chk (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       dout,
  input logic [1:0] state_o
);

  AST_RESET_HOME: assert property (@(posedge clk) rst |=> (state_o == 2'b00 && dout == 1'b0)); // R1
  AST_OUT_LOW_BIT: assert property (@(posedge clk) disable iff (rst) $past(!rst) |-> (dout == state_o[0])); // R2
  AST_FROM_Q0: assert property (@(posedge clk) disable iff (rst) (state_o == 2'b00) |=> (state_o == ($past(din) ? 2'b01 : 2'b00))); // R3
  AST_FROM_Q1: assert property (@(posedge clk) disable iff (rst) (state_o == 2'b01) |=> (state_o == ($past(din) ? 2'b00 : 2'b11))); // R4
  AST_FROM_Q2: assert property (@(posedge clk) disable iff (rst) (state_o == 2'b10) |=> (state_o == ($past(din) ? 2'b01 : 2'b00))); // R5
  AST_FROM_Q3: assert property (@(posedge clk) disable iff (rst) (state_o == 2'b11) |=> (state_o == ($past(din) ? 2'b00 : 2'b10))); // R6
  AST_RESET_WINS: assert property (@(posedge clk) (rst && din) |=> (state_o == 2'b00)); // R7

endmodule

bind seq4_moore seq4_moore_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .dout    (dout),
  .state_o (state_o)
);

// File: tb/seq4_moore_bench.sv
module seq4_moore_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic       dout;
  logic [1:0] state_o;

  typedef struct {
    logic [1:0] st;
    logic       o;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         n_cmp  = 0;
  int         n_bad  = 0;
  logic [1:0] model  = 2'b00;
  bit         stim_done = 1'b0;
  bit         ended = 1'b0;

  always #10 clk = ~clk;

  seq4_moore u_seq4_moore (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .dout    (dout),
    .state_o (state_o)
  );

  // Expected next code, written from R3..R6
  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic x);
    case (s)
      2'b00:   return x ? 2'b01 : 2'b00; // R3
      2'b01:   return x ? 2'b00 : 2'b11; // R4
      2'b10:   return x ? 2'b01 : 2'b00; // R5
      default: return x ? 2'b00 : 2'b10; // R6
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] s);
    case (s)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic push(input logic [1:0] st, input string req);
    exp_t e;
    e.st  = st;
    e.o   = st[0]; // R2
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic do_reset(input logic x, input string req);
    @(negedge clk);
    rst = 1'b1;
    din = x;
    model = 2'b00;
    push(2'b00, req);
  endtask

  task automatic step(input logic x);
    string r;
    @(negedge clk);
    rst = 1'b0;
    din = x;
    r = req_of(model);
    model = ref_next(model, x);
    push(model, r);
  endtask

  task automatic reach(input logic [1:0] s);
    do_reset(1'b0, "R1");
    case (s)
      2'b01: step(1'b1);
      2'b11: begin step(1'b1); step(1'b0); end
      2'b10: begin step(1'b1); step(1'b0); step(1'b0); end
      default: ;
    endcase
  endtask

  // Monitor: compare after every edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (state_o !== e.st || dout !== e.o) begin
          n_bad++;
          $display("FAIL %s: state=%b dout=%b expected state=%b dout=%b",
                   e.req, state_o, dout, e.st, e.o);
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver
  initial begin
    do_reset(1'b0, "R1");
    // every state/input pair from a fresh reset (R3..R6, R2 on each)
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 2; x++) begin
        reach(2'(s));
        step(1'(x));
      end
    end
    // R7: reset with input high, and reset from the deepest state
    do_reset(1'b1, "R7");
    reach(2'b11);
    do_reset(1'b1, "R7");
    step(1'b1);
    step(1'b0);
    step(1'b0);
    do_reset(1'b0, "R7");
    // a longer run mixing inputs
    step(1'b1); step(1'b1); step(1'b1); step(1'b0); step(1'b0);
    step(1'b1); step(1'b0); step(1'b0); step(1'b0); step(1'b1);
    @(negedge clk);
    din = 1'b0;
    repeat (3) @(negedge clk);
    stim_done = 1'b1;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d expected items left unmatched, expected 0", sb.size());
    end
    finish_run();
  end

  // Watchdog
  initial begin
    #(200000 * 20);
    if (!stim_done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired, run done=%0d expected 1", stim_done);
    end
    finish_run();
  end

endmodule